// File: doc/BRIEF.md
# SDRAM Single-Bank Command Timing Controller

This block drives the command stream for one SDRAM bank. A requester presents read or write requests, each carrying a row and a column. For each request the block issues whatever command comes next: it opens the row, accesses the column, or closes a different row that is still open. Every command waits until the minimum intervals since earlier commands have passed. The five interval lengths are whole-cycle values that can be changed at run time.

The row stays open after an access. Further requests to that row issue one column command per clock, and the row closes only when a request targets a different row. Reads return through a pipeline that marks data valid a fixed number of cycles after each read command. Several reads can be in flight in that pipeline at the same time.

Top module: `sdr_bank_ctrl`

## Requirements
- R1: After reset no row is open, `cmd_o` is NOP (0), `req_ready_o` and `rd_valid_o` are low. A request that arrives while no row is open first causes ACT (1), and in that cycle `cmd_addr_o` carries the requested row.
- R2: READ (2) or WRITE (3) issues no earlier than `t_rcd_i` cycles after the ACT. When a request to that row is already waiting, the command issues exactly `t_rcd_i` cycles after the ACT.
- R3: While the requested row is open, one READ or WRITE issues in every cycle with a valid request. `req_ready_o` is high in that cycle and `cmd_addr_o` carries the column.
- R4: `rd_valid_o` is high exactly `t_cas_i` cycles after each READ, including when reads overlap in the pipeline.
- R5: A request to a row other than the open one causes PRE (4). The next ACT issues no earlier than `t_rp_i` cycles after the PRE, and exactly then if the request is still waiting.
- R6: PRE issues no earlier than the effective active time after the ACT. The effective active time is the larger of `t_ras_i` and `t_rcd_i + t_cas_i + 2`.
- R7: PRE issues no earlier than `t_wr_i` cycles after the last WRITE to the open row.
- R8: PRE issues in the first cycle in which both R6 and R7 hold. With no request pending, the open row stays open and no PRE issues.
- R9: At most one command issues per cycle. `cmd_o` is NOP whenever `req_valid_i` is low or the needed command is still blocked, and `req_ready_o` is high only when a READ or WRITE issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request consumed this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_row_i | input | ROW_W | Request row |
| req_col_i | input | COL_W | Request column |
| t_cas_i | input | TW | Read return latency, at least 1 |
| t_rcd_i | input | TW | Open-to-column delay, at least 1 |
| t_rp_i | input | TW | Close-to-open delay, at least 1 |
| t_ras_i | input | TW | Minimum active time, at least 1 |
| t_wr_i | input | TW | Write-to-close delay, at least 1 |
| cmd_o | output | 3 | Command: 0 NOP, 1 ACT, 2 READ, 3 WRITE, 4 PRE |
| cmd_addr_o | output | AW | Row on ACT, column otherwise |
| rd_valid_o | output | 1 | Read data valid |
| open_o | output | 1 | A row is open |
| open_row_o | output | ROW_W | The open row |

## Verification
Two kinds of event can fall in the same cycle: a read return from an earlier READ, and a new column command or a PRE. The bench provokes this with back-to-back reads and a write to one row, then sends a request to another row while reads are still in flight. A read return must not suppress the close, and the close must not drop the return. Each issued command is also judged against the cycle counts since the last ACT, PRE and WRITE. Each read return is judged against the exact cycle its READ predicts.

// File: rtl/sdr_bank_pkg.sv
package sdr_bank_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } sdr_cmd_e;
endpackage

// File: rtl/sdr_down_cnt.sv
// Saturating down-counter; a load of v makes zero_o true v cycles later.
module sdr_down_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i - W'(1);
    else if (cnt_q != '0)  cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sdr_rd_pipe.sv
module sdr_rd_pipe #(
  parameter int TW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          issue_i,
  input  logic [TW-1:0] lat_i,
  output logic          valid_o
);
  localparam int DEPTH = 2 ** TW;

  logic [DEPTH-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[DEPTH-2:0], issue_i};
  end

  // sr_q[k-1] holds a read issued k cycles ago
  assign valid_o = sr_q[lat_i - TW'(1)];
endmodule

// File: rtl/sdr_bank_ctrl.sv
module sdr_bank_ctrl
  import sdr_bank_pkg::*;
#(
  parameter int ROW_W = 13,
  parameter int COL_W = 10,
  parameter int TW    = 4,
  parameter int AW    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_write_i,
  input  logic [ROW_W-1:0] req_row_i,
  input  logic [COL_W-1:0] req_col_i,
  input  logic [TW-1:0]    t_cas_i,
  input  logic [TW-1:0]    t_rcd_i,
  input  logic [TW-1:0]    t_rp_i,
  input  logic [TW-1:0]    t_ras_i,
  input  logic [TW-1:0]    t_wr_i,
  output logic [2:0]       cmd_o,
  output logic [AW-1:0]    cmd_addr_o,
  output logic             rd_valid_o,
  output logic             open_o,
  output logic [ROW_W-1:0] open_row_o
);
  localparam int EW = TW + 2;

  sdr_cmd_e         cmd;
  logic             ready;
  logic             open_q;
  logic [ROW_W-1:0] row_q;
  logic             rcd_zero, ras_zero, wr_zero, rp_zero;
  logic [EW-1:0]    ras_floor, ras_eff;

  // active time floor keeps a read streaming before close
  assign ras_floor = EW'(t_rcd_i) + EW'(t_cas_i) + EW'(2);
  assign ras_eff   = (EW'(t_ras_i) < ras_floor) ? ras_floor : EW'(t_ras_i);

  always_comb begin
    cmd   = CMD_NOP;
    ready = 1'b0;
    if (req_valid_i) begin
      if (!open_q) begin
        if (rp_zero) cmd = CMD_ACT;
      end else if (row_q == req_row_i) begin
        if (rcd_zero) begin
          cmd   = req_write_i ? CMD_WR : CMD_RD;
          ready = 1'b1;
        end
      end else if (ras_zero && wr_zero) begin
        cmd = CMD_PRE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (cmd == CMD_ACT) begin
      open_q <= 1'b1;
      row_q  <= req_row_i;
    end else if (cmd == CMD_PRE) begin
      open_q <= 1'b0;
    end
  end

  sdr_down_cnt #(.W(TW)) u_rcd (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(cmd == CMD_ACT),
    .val_i(t_rcd_i), .zero_o(rcd_zero));

  sdr_down_cnt #(.W(EW)) u_ras (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(cmd == CMD_ACT),
    .val_i(ras_eff), .zero_o(ras_zero));

  sdr_down_cnt #(.W(TW)) u_wr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(cmd == CMD_WR),
    .val_i(t_wr_i), .zero_o(wr_zero));

  sdr_down_cnt #(.W(TW)) u_rp (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(cmd == CMD_PRE),
    .val_i(t_rp_i), .zero_o(rp_zero));

  sdr_rd_pipe #(.TW(TW)) u_rd_pipe (
    .clk_i(clk_i), .rst_ni(rst_ni), .issue_i(cmd == CMD_RD),
    .lat_i(t_cas_i), .valid_o(rd_valid_o));

  assign cmd_o       = cmd;
  assign req_ready_o = ready;
  assign cmd_addr_o  = (cmd == CMD_ACT) ? AW'(req_row_i) : AW'(req_col_i);
  assign open_o      = open_q;
  assign open_row_o  = row_q;
endmodule

// File: rtl/sdr_bank_ctrl_chk.sv
module sdr_bank_ctrl_chk #(
  parameter int ROW_W = 13,
  parameter int TW    = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [ROW_W-1:0] req_row_i,
  input logic [TW-1:0]    t_cas_i,
  input logic [TW-1:0]    t_rcd_i,
  input logic [TW-1:0]    t_rp_i,
  input logic [TW-1:0]    t_ras_i,
  input logic [TW-1:0]    t_wr_i,
  input logic [2:0]       cmd_o,
  input logic             open_o,
  input logic [ROW_W-1:0] open_row_o
);
  logic [7:0] s_act, s_pre, s_wr;
  logic [7:0] ras_need;
  logic       is_col;

  assign is_col   = (cmd_o == 3'd2) || (cmd_o == 3'd3);
  assign ras_need = (8'(t_ras_i) > 8'(t_rcd_i) + 8'(t_cas_i) + 8'd2) ?
                    8'(t_ras_i) : 8'(t_rcd_i) + 8'(t_cas_i) + 8'd2;

  // cycles since the last ACT, PRE and WRITE, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_act <= 8'hff;
      s_pre <= 8'hff;
      s_wr  <= 8'hff;
    end else begin
      s_act <= (cmd_o == 3'd1) ? 8'd1 : (s_act == 8'hff ? s_act : s_act + 8'd1);
      s_pre <= (cmd_o == 3'd4) ? 8'd1 : (s_pre == 8'hff ? s_pre : s_pre + 8'd1);
      s_wr  <= (cmd_o == 3'd3) ? 8'd1 : (s_wr  == 8'hff ? s_wr  : s_wr  + 8'd1);
    end
  end

  AST_NEED_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_col || cmd_o == 3'd4) |-> open_o);                       // R1
  AST_COL_AFTER_RCD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_col |-> (s_act >= 8'(t_rcd_i)));                          // R2
  AST_COL_ON_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_col |-> (open_row_o == req_row_i));                       // R3
  AST_ACT_AFTER_RP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 3'd1) |-> (s_pre >= 8'(t_rp_i)));                  // R5
  AST_PRE_AFTER_RAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 3'd4) |-> (s_act >= ras_need));                    // R6
  AST_PRE_AFTER_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 3'd4) |-> (s_wr >= 8'(t_wr_i)));                   // R7
  AST_IDLE_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> (cmd_o == 3'd0));                           // R9
  AST_CMD_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o <= 3'd4);                                              // R9
endmodule

bind sdr_bank_ctrl sdr_bank_ctrl_chk #(.ROW_W(ROW_W), .TW(TW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_row_i(req_row_i), .t_cas_i(t_cas_i), .t_rcd_i(t_rcd_i),
  .t_rp_i(t_rp_i), .t_ras_i(t_ras_i), .t_wr_i(t_wr_i), .cmd_o(cmd_o),
  .open_o(open_o), .open_row_o(open_row_o));

// File: tb/sdr_bank_ctrl_test.sv
module sdr_bank_ctrl_test;
  localparam int ROW_W = 13;
  localparam int COL_W = 10;
  localparam int TW    = 4;
  localparam int AW    = 13;

  // {write, row, col, expected wait cycles} with cas3 rcd2 rp2 ras4 wr3
  localparam int NV = 7;
  localparam int VEC [NV][4] = '{
    '{0, 1, 0, 2},   // ACT then READ after rcd
    '{1, 1, 1, 0},   // back-to-back WRITE
    '{0, 1, 2, 0},   // back-to-back READ
    '{0, 2, 3, 6},   // miss: clamped ras dominates
    '{1, 2, 5, 0},
    '{0, 3, 4, 7},   // miss after write
    '{0, 3, 6, 0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [TW-1:0] t_cas = 4'd3, t_rcd = 4'd2, t_rp = 4'd2, t_ras = 4'd4, t_wr = 4'd3;
  logic req_ready, rd_valid, open_w;
  logic [2:0] cmd;
  logic [AW-1:0] cmd_addr;
  logic [ROW_W-1:0] open_row;

  int total = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sdr_bank_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .TW(TW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_row_i(req_row), .req_col_i(req_col),
    .t_cas_i(t_cas), .t_rcd_i(t_rcd), .t_rp_i(t_rp), .t_ras_i(t_ras), .t_wr_i(t_wr),
    .cmd_o(cmd), .cmd_addr_o(cmd_addr), .rd_valid_o(rd_valid),
    .open_o(open_w), .open_row_o(open_row));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  // command monitor: judges each command against the intervals since earlier ones
  int last_act, last_pre, last_wr;
  int pend [16];
  always @(negedge clk) begin
    #2;
    if (!rst_n) begin
      last_act = -1000; last_pre = -1000; last_wr = -1000;
      foreach (pend[i]) pend[i] = -1;
    end else begin
      int ras_eff;
      bit exp_v;
      ras_eff = (int'(t_ras) > int'(t_rcd) + int'(t_cas) + 2) ?
                int'(t_ras) : int'(t_rcd) + int'(t_cas) + 2;
      case (cmd)
        3'd1: begin
          check(cyc - last_pre >= int'(t_rp), "R5 ACT after PRE", cyc - last_pre, int'(t_rp));
          check(cmd_addr == AW'(req_row), "R1 ACT row", int'(cmd_addr), int'(req_row));
          last_act = cyc;
        end
        3'd2, 3'd3: begin
          check(cyc - last_act >= int'(t_rcd), "R2 column after ACT", cyc - last_act, int'(t_rcd));
          check(cmd_addr == AW'(req_col), "R3 column address", int'(cmd_addr), int'(req_col));
          if (cmd == 3'd3) last_wr = cyc;
          else begin
            for (int i = 0; i < 16; i++)
              if (pend[i] < 0) begin pend[i] = cyc + int'(t_cas); break; end
          end
        end
        3'd4: begin
          check(cyc - last_act >= ras_eff, "R6 PRE after ACT", cyc - last_act, ras_eff);
          check(cyc - last_wr >= int'(t_wr), "R7 PRE after WRITE", cyc - last_wr, int'(t_wr));
          last_pre = cyc;
        end
        default: ;
      endcase
      exp_v = 1'b0;
      for (int i = 0; i < 16; i++)
        if (pend[i] == cyc) begin exp_v = 1'b1; pend[i] = -1; end
      if (exp_v || rd_valid)
        check(rd_valid == exp_v, "R4 read return", int'(rd_valid), int'(exp_v));
    end
  end

  task automatic send(input bit wr, input int row, input int col, input int exp_w,
                      input string tag);
    int w;
    w = 0;
    req_valid = 1'b1; req_write = wr; req_row = ROW_W'(row); req_col = COL_W'(col);
    #1;
    while (!req_ready && w < 60) begin
      @(negedge clk); #1;
      w++;
    end
    check(w == exp_w, tag, w, exp_w);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_reset();
    req_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin
    string tag [NV];
    tag = '{"R2 first access", "R3 write hit", "R3 read hit", "R6 clamped close",
            "R3 write hit", "R7 close after write", "R3 read hit"};
    // reset state
    repeat (2) @(negedge clk);
    #1;
    check(cmd == 3'd0, "R1 reset cmd", int'(cmd), 0);
    check(open_w == 1'b0, "R1 reset open", int'(open_w), 0);
    check(req_ready == 1'b0, "R1 reset ready", int'(req_ready), 0);
    check(rd_valid == 1'b0, "R1 reset rd_valid", int'(rd_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(cmd == 3'd0, "R9 idle NOP", int'(cmd), 0);
    req_valid = 1'b1; req_row = 13'd1; #1;
    check(cmd == 3'd1, "R1 first command ACT", int'(cmd), 1);
    req_valid = 1'b0;

    // vector walk, restarted from reset so the first request lands in cycle 0
    do_reset();
    for (int i = 0; i < NV; i++)
      send(VEC[i][0] != 0, VEC[i][1], VEC[i][2], VEC[i][3], tag[i]);
    repeat (6) @(negedge clk);

    // write recovery dominates the close
    t_cas = 4'd1; t_rcd = 4'd1; t_rp = 4'd1; t_ras = 4'd1; t_wr = 4'd8;
    do_reset();
    send(1'b1, 0, 0, 1, "R2 write after ACT");
    send(1'b0, 5, 2, 9, "R7 wr-limited close");

    // idle row stays open
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #1;
      check(cmd == 3'd0 && open_w, "R8 idle keeps row", int'(cmd), 0);
    end
    check(open_row == 13'd5, "R8 open row", int'(open_row), 5);
    send(1'b0, 5, 9, 0, "R8 hit after idle");
    repeat (6) @(negedge clk);
    finish_up();
  end
endmodule